// File: doc/BRIEF.md
# Flash Status Read Responder

This block answers bus reads for a multi-bank NOR flash model while its embedded program or erase algorithm runs. A read strobe edge samples an address. If the address lies in the bank that is busy, the reply is a status byte instead of array contents. Otherwise the reply is the stored word.

Bit 7 of the status byte is a polling flag. It is the inverted top bit of the value being programmed, or 0 during an erase. Bit 6 flips on every status read. Software can therefore tell a running operation from a finished one by reading the same location twice.

An erase can be suspended. While it is suspended, reads inside the block being erased report a polling flag of 1 and a frozen toggle. All other locations read as plain data. The embedded algorithm's duration is a fixed count of clock cycles, and that count is a parameter. When the operation finishes, the result is written into a small register array.

Top module: `nsr_top`

## Requirements
- R1: A read is taken when rd_en is seen high at a clock edge after being low at the previous edge. rd_data and rd_valid appear one clock after that edge, and rd_valid lasts one cycle. Holding rd_en high gives exactly one read.
- R2: After reset, busy, suspended and rd_valid are 0 and every array word reads 0xFF.
- R3: When busy is low, op_start is accepted and busy is high for exactly BUSY_CYCLES cycles of running time. While busy is high, op_start is ignored.
- R4: While busy and not suspended, a read whose bank field (rd_addr[5] at default parameters) matches the operation's bank returns the status byte, whatever the rest of the address is.
- R5: During a program, status bit 7 equals the inverse of op_data[7]. During an erase (op_erase = 1), status bit 7 is 0.
- R6: Bit 6 is 0 on the first status read after an operation is accepted, and it inverts on each later status read.
- R7: On completion, a program stores op_data at op_addr, and reads of that address return it uninverted. An erase sets all words of the target block (same rd_addr[5:3]) to 0xFF.
- R8: suspend_req during a running erase sets suspended from the next cycle. suspend_req during a program is ignored. resume_req clears suspended. The busy time does not advance while suspended.
- R9: While suspended, reads in the block being erased return status with bit 7 = 1 and bit 6 held. Reads in other blocks or in the other bank return array data.
- R10: Status bits 5 to 0 are always 0.
- R11: While busy, reads from a bank other than the operation's bank return array data and do not change bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe; its rising edge starts a read |
| rd_addr | input | 6 | Read address: bank, block, word from the top bit down |
| rd_data | output | 8 | Read reply: array word or status byte |
| rd_valid | output | 1 | One-cycle flag marking rd_data as a new reply |
| op_start | input | 1 | Start a program or erase |
| op_erase | input | 1 | 1 = erase the block of op_addr, 0 = program op_addr |
| op_addr | input | 6 | Operation target address |
| op_data | input | 8 | Data to program |
| suspend_req | input | 1 | Request erase suspend |
| resume_req | input | 1 | Request resume of a suspended erase |
| busy | output | 1 | Embedded operation in progress, including while suspended |
| suspended | output | 1 | Erase is suspended |

## Verification
Every read reply is due exactly one clock after the edge that first sees rd_en high. The bench raises rd_en at a falling edge and lowers it at the next one. The scoreboard monitor compares each valid reply at the falling edge that follows the sampling edge, so every item it pops is matched to the read that pushed it. An extra or missing reply shows up as a queue mismatch.

The busy window is counted in falling edges from the one after op_start. It must cover exactly BUSY_CYCLES edges. suspended is checked one falling edge after suspend_req or resume_req is driven. Completion results are read only after busy has been seen low.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } op_kind_e;

   localparam int STAT_POLL_POS   = 7;
   localparam int STAT_TOGGLE_POS = 6;

   // Status byte: polling flag and toggle flag, remaining bits zero.
   function automatic logic [7:0] pack_status(input logic poll, input logic tog);
      logic [7:0] s;
      s = 8'h00;
      s[STAT_POLL_POS]   = poll;
      s[STAT_TOGGLE_POS] = tog;
      return s;
   endfunction

endpackage

// File: rtl/nsr_op_ctrl.sv
module nsr_op_ctrl
   import nsr_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int BUSY_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              op_erase,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_data,
   input  logic              suspend_req,
   input  logic              resume_req,
   output logic              busy,
   output logic              suspended,
   output op_kind_e          kind,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [DATA_W-1:0] tgt_data,
   output logic              accept,
   output logic              commit
);

   localparam int              CNT_W    = $clog2(BUSY_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUSY_CYCLES - 1);

   logic              busy_q, susp_q;
   logic [CNT_W-1:0]  cnt_q;
   op_kind_e          kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign accept = op_start && !busy_q;
   assign commit = busy_q && !susp_q && (cnt_q == CNT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         susp_q <= 1'b0;
         cnt_q  <= '0;
         kind_q <= OP_PROGRAM;
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         susp_q <= 1'b0;
         cnt_q  <= '0;
         kind_q <= op_erase ? OP_ERASE : OP_PROGRAM;
         addr_q <= op_addr;
         data_q <= op_data;
      end else if (commit) begin
         busy_q <= 1'b0;
      end else if (susp_q) begin
         if (resume_req) susp_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (suspend_req && kind_q == OP_ERASE) susp_q <= 1'b1;
      end
   end

   assign busy      = busy_q;
   assign suspended = susp_q;
   assign kind      = kind_q;
   assign tgt_addr  = addr_q;
   assign tgt_data  = data_q;

   AST_SUSP_ONLY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |-> (busy_q && kind_q == OP_ERASE));                     // R8
   AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |=> $stable(cnt_q));                                     // R8
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> ($stable(addr_q) && $stable(data_q)));               // R3

endmodule

// File: rtl/nsr_array.sv
module nsr_array #(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int WORD_BITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word,
   input  logic              prog_we,
   input  logic              erase_we,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
      logic              hit_prog, hit_erase;
      logic [DATA_W-1:0] word_q;

      assign hit_prog  = prog_we && (wr_addr == WA);
      assign hit_erase = erase_we &&
                         (wr_addr[ADDR_W-1:WORD_BITS] == WA[ADDR_W-1:WORD_BITS]);

      always_ff @(posedge clk) begin
         if (!rst_n)         word_q <= '1;
         else if (hit_erase) word_q <= '1;
         else if (hit_prog)  word_q <= wr_data;
      end

      assign words[w] = word_q;
   end

   assign rd_word = words[rd_addr];

endmodule

// File: rtl/nsr_read_mux.sv
module nsr_read_mux
   import nsr_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int BANK_BITS = 1,
   parameter int WORD_BITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] array_word,
   input  logic              busy,
   input  logic              suspended,
   input  op_kind_e          kind,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic [DATA_W-1:0] tgt_data,
   input  logic              accept,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   localparam int BANK_LSB = ADDR_W - BANK_BITS;

   logic              rd_en_q, tog_q, valid_q, stat_q;
   logic [DATA_W-1:0] data_q;
   logic              rise, same_bank, same_block;
   logic              use_status, live, poll;

   assign rise       = rd_en && !rd_en_q;
   assign same_bank  = rd_addr[ADDR_W-1:BANK_LSB] == tgt_addr[ADDR_W-1:BANK_LSB];
   assign same_block = rd_addr[ADDR_W-1:WORD_BITS] == tgt_addr[ADDR_W-1:WORD_BITS];

   always_comb begin
      use_status = 1'b0;
      live       = 1'b0;
      poll       = 1'b0;
      if (busy && same_bank) begin
         if (suspended) begin
            use_status = same_block;
            poll       = 1'b1;
         end else begin
            use_status = 1'b1;
            live       = 1'b1;
            poll       = (kind == OP_PROGRAM) ? ~tgt_data[STAT_POLL_POS] : 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_en_q <= 1'b0;
         tog_q   <= 1'b0;
         valid_q <= 1'b0;
         stat_q  <= 1'b0;
         data_q  <= '0;
      end else begin
         rd_en_q <= rd_en;
         valid_q <= rise;
         if (rise) begin
            stat_q <= use_status;
            data_q <= use_status ? DATA_W'(pack_status(poll, tog_q)) : array_word;
         end
         if (accept)            tog_q <= 1'b0;
         else if (rise && live) tog_q <= ~tog_q;
      end
   end

   assign rd_data  = data_q;
   assign rd_valid = valid_q;

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);                                          // R1
   AST_TOGGLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !tog_q);                                             // R6
   AST_TOGGLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |=> $stable(tog_q));                                  // R9
   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && stat_q) |-> (data_q[5:0] == 6'd0));                 // R10

endmodule

// File: rtl/nsr_top.sv
module nsr_top
   import nsr_pkg::*;
#(
   parameter int  BANK_BITS   = 1,
   parameter int  BLOCK_BITS  = 2,
   parameter int  WORD_BITS   = 3,
   parameter int  DATA_W      = 8,
   parameter int  BUSY_CYCLES = 20,
   localparam int ADDR_W      = BANK_BITS + BLOCK_BITS + WORD_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic              op_start,
   input  logic              op_erase,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_data,
   input  logic              suspend_req,
   input  logic              resume_req,
   output logic              busy,
   output logic              suspended
);

   if (DATA_W < 8) begin : g_bad_width
      $error("nsr_top: DATA_W must hold an 8-bit status byte");
   end
   if (BUSY_CYCLES < 2) begin : g_bad_busy
      $error("nsr_top: BUSY_CYCLES must be at least 2");
   end
   if (BANK_BITS < 1 || BLOCK_BITS < 1 || WORD_BITS < 1) begin : g_bad_map
      $error("nsr_top: every address field needs at least one bit");
   end
   if (ADDR_W > 10) begin : g_bad_depth
      $error("nsr_top: array model limited to 1024 words");
   end

   op_kind_e          kind;
   logic [ADDR_W-1:0] tgt_addr;
   logic [DATA_W-1:0] tgt_data, array_word;
   logic              accept, commit;

   nsr_op_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
      .op_addr(op_addr), .op_data(op_data), .suspend_req(suspend_req),
      .resume_req(resume_req), .busy(busy), .suspended(suspended), .kind(kind),
      .tgt_addr(tgt_addr), .tgt_data(tgt_data), .accept(accept), .commit(commit)
   );

   nsr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BITS(WORD_BITS)) u_array (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_word(array_word),
      .prog_we(commit && kind == OP_PROGRAM), .erase_we(commit && kind == OP_ERASE),
      .wr_addr(tgt_addr), .wr_data(tgt_data)
   );

   nsr_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_BITS(BANK_BITS),
                  .WORD_BITS(WORD_BITS)) u_mux (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
      .array_word(array_word), .busy(busy), .suspended(suspended), .kind(kind),
      .tgt_addr(tgt_addr), .tgt_data(tgt_data), .accept(accept),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   AST_REPLY_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_en));                                     // R1

endmodule

// File: tb/nsr_top_tb.sv
module nsr_top_tb;

   localparam int BUSY_CYCLES = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_en = 1'b0;
   logic [5:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       op_start = 1'b0;
   logic       op_erase = 1'b0;
   logic [5:0] op_addr = '0;
   logic [7:0] op_data = '0;
   logic       suspend_req = 1'b0;
   logic       resume_req = 1'b0;
   logic       busy, suspended;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   nsr_top #(.BUSY_CYCLES(BUSY_CYCLES)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_valid(rd_valid), .op_start(op_start),
      .op_erase(op_erase), .op_addr(op_addr), .op_data(op_data),
      .suspend_req(suspend_req), .resume_req(resume_req),
      .busy(busy), .suspended(suspended)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // Monitor: pops one expected reply per valid output.
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R1 unexpected reply", rd_data, 0);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data == e, t, rd_data, e);
         end
      end
   end

   task automatic rd(input logic [5:0] a, input logic [7:0] e, input string req);
      exp_q.push_back(e);
      tag_q.push_back(req);
      rd_addr = a;
      rd_en   = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic start(input bit er, input logic [5:0] a, input logic [7:0] d);
      op_erase = er;
      op_addr  = a;
      op_data  = d;
      op_start = 1'b1;
      @(negedge clk);
      op_start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state
      check(busy == 1'b0 && suspended == 1'b0 && rd_valid == 1'b0, "R2 reset outputs",
            {busy, suspended, rd_valid}, 0);
      rd(6'h00, 8'hFF, "R2 erased after reset");
      rd(6'h3F, 8'hFF, "R2 erased after reset top word");

      // R1: held strobe gives a single reply, one cycle long
      exp_q.push_back(8'hFF);
      tag_q.push_back("R1 held strobe");
      rd_addr = 6'h11;
      rd_en   = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(rd_valid == 1'b0, "R1 valid is one cycle", rd_valid, 0);
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
      check(exp_q.size() == 0, "R1 one reply for held strobe", exp_q.size(), 0);

      // R3: busy window length without reads
      start(1'b0, 6'h10, 8'h33);
      begin
         int cnt;
         cnt = 0;
         for (int i = 0; i < 100 && busy; i++) begin
            cnt++;
            @(negedge clk);
         end
         check(cnt == BUSY_CYCLES, "R3 busy length", cnt, BUSY_CYCLES);
      end
      rd(6'h10, 8'h33, "R7 programmed data");

      // R4 R5 R6 R11: program 0x5A at 0x05 (bank 0)
      start(1'b0, 6'h05, 8'h5A);
      check(busy == 1'b1, "R3 busy after start", busy, 1);
      rd(6'h05, 8'h80, "R5 program poll inverted, R6 first toggle 0");
      rd(6'h05, 8'hC0, "R6 toggle second read");
      rd(6'h12, 8'h80, "R4 status at other address same bank");
      rd(6'h25, 8'hFF, "R11 other bank array data");
      rd(6'h07, 8'hC0, "R11 toggle unchanged by other bank");
      // R3: start while busy is ignored
      start(1'b0, 6'h06, 8'h00);
      // R8: suspend during program ignored
      suspend_req = 1'b1;
      @(negedge clk);
      suspend_req = 1'b0;
      check(suspended == 1'b0, "R8 suspend ignored in program", suspended, 0);
      wait_idle();
      check(busy == 1'b0, "R3 program completes", busy, 0);
      rd(6'h05, 8'h5A, "R7 true data after program");
      rd(6'h06, 8'hFF, "R3 start while busy ignored");

      // program 0x81 at 0x2B, poll bit 0 during program
      start(1'b0, 6'h2B, 8'h81);
      rd(6'h2B, 8'h00, "R5 program poll of 1 gives 0");
      wait_idle();
      rd(6'h2B, 8'h81, "R7 programmed high bit");
      rd(6'h2C, 8'hFF, "R7 neighbour untouched");

      // erase block of 0x2B (0x28..0x2F), with suspend
      start(1'b1, 6'h28, 8'h00);
      rd(6'h2B, 8'h00, "R5 erase poll 0, R6 toggle cleared at start");
      rd(6'h2B, 8'h40, "R6 erase toggle");
      suspend_req = 1'b1;
      @(negedge clk);
      suspend_req = 1'b0;
      check(suspended == 1'b1, "R8 suspend entered", suspended, 1);
      rd(6'h2B, 8'h80, "R9 suspended poll 1");
      rd(6'h2D, 8'h80, "R9 toggle held while suspended");
      rd(6'h30, 8'hFF, "R9 other block array data");
      rd(6'h05, 8'h5A, "R9 other bank array data");
      repeat (40) @(negedge clk);
      check(busy == 1'b1 && suspended == 1'b1, "R8 time frozen while suspended",
            {busy, suspended}, 3);
      resume_req = 1'b1;
      @(negedge clk);
      resume_req = 1'b0;
      check(suspended == 1'b0, "R8 resume", suspended, 0);
      rd(6'h2B, 8'h00, "R6 toggle resumes, R5 erase poll 0");
      rd(6'h2B, 8'h40, "R6 toggle after resume");
      wait_idle();
      rd(6'h2B, 8'hFF, "R7 erase filled block");
      rd(6'h28, 8'hFF, "R7 erase first word");
      rd(6'h10, 8'h33, "R7 erase leaves other bank");

      @(negedge clk);
      check(exp_q.size() == 0, "R1 all replies received", exp_q.size(), 0);
      finish_run();
   end

endmodule